// File: doc/BRIEF.md
# Z80 Boot Instruction Injector

This block brings up a Z80 with an empty RAM and no address decoding. It produces the CPU clock and the CPU reset. It then watches only the read strobe, /M1 and the write strobe, and counts bus cycles. On each read the sequencer expects, it puts an opcode or operand byte of its own choosing on the data bus. While it does this, RAM is kept from driving the bus.

The injected stream first sets DE to zero. For every byte of the boot image it then performs three steps:

- Load A with the image byte, read from a simple byte-read port on the ROM source.
- Store A through DE. The block leaves the bus free during the CPU's write so the byte lands in RAM.
- Increment DE, followed by a short pause.

When the whole image is in RAM, the block feeds a jump to address zero. It then hands instruction fetches back to RAM and raises a done flag.

Top module: `zboot_injector`

## Requirements
- R1: `cpu_clk` is `clk` divided by CLK_DIV with a 50% duty cycle (4 clk cycles per CPU cycle by default).
- R2: After `rst_n` is released, `cpu_rst_n` stays low for exactly RST_HOLD clk cycles and then rises. Reads in that time are never driven (`d_oe` low).
- R3: A read cycle is `rd_n` low. An opcode slot is served only when `m1_n` is also low, and an operand slot only when `m1_n` is high. A read that does not match the slot gets `d_oe` low and does not advance the sequence. `d_oe` is never high while `rd_n` is high.
- R4: The first three served reads return 0x11, 0x00, 0x00.
- R5: For each image byte, an opcode read returns 0x3E and the next operand read returns `rom_data`. `rom_addr` starts at 0 and increases by exactly one when that operand read ends.
- R6: The next opcode read returns 0x12. During the following write cycle (`wr_n` low) `d_oe` stays low. The sequence waits for the end of that write.
- R7: The next opcode read returns 0x13. For 2*CLK_DIV clk cycles after that read ends, reads are not driven and do not advance the sequence.
- R8: The 0x3E / operand / 0x12 / write / 0x13 loop runs exactly IMG_LEN times before the jump starts.
- R9: After the loop, three served reads return 0xC3, 0x00, 0x00.
- R10: When the last jump read ends, `done` and `ram_oe_allow` go high and stay high until reset. After that `d_oe` stays low.
- R11: `ram_oe_allow` is low from reset until R10, and is never high while `d_oe` is high.
- R12: Asserting `rst_n` at any time restarts the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_clk | output | 1 | Divided clock for the CPU |
| cpu_rst_n | output | 1 | Active-low CPU reset |
| m1_n | input | 1 | CPU opcode-fetch marker, active low |
| rd_n | input | 1 | CPU memory read strobe, active low |
| wr_n | input | 1 | CPU memory write strobe, active low |
| d_out | output | 8 | Injected data byte |
| d_oe | output | 1 | Drive enable for `d_out` onto the CPU data bus |
| rom_addr | output | ADDR_W | Image byte address to the ROM source |
| rom_data | input | 8 | Image byte at `rom_addr` |
| ram_oe_allow | output | 1 | High when RAM may drive reads |
| done | output | 1 | Boot copy and jump complete |

## Verification
The bench builds the block with IMG_LEN=3, RST_HOLD=8 and CLK_DIV=4. With these values the full 18-read stream fits in a short table, and both the first and the last pass of the copy loop can be checked, including the hand-over from the final pause into the jump. The short hold and pause windows make it cheap to place ignored reads inside them. A second reset after completion shows that the sequence restarts.

// File: rtl/zboot_pkg.sv
package zboot_pkg;

  typedef enum logic [3:0] {
    S_HOLD, S_LDDE, S_LDA, S_STORE, S_WRITE, S_INCDE, S_PAUSE, S_JUMP, S_DONE
  } seq_e;

  localparam logic [7:0] OP_LD_DE = 8'h11;
  localparam logic [7:0] OP_LD_A  = 8'h3E;
  localparam logic [7:0] OP_ST_DE = 8'h12;
  localparam logic [7:0] OP_INC   = 8'h13;
  localparam logic [7:0] OP_JP    = 8'hC3;

  // states that answer read cycles
  function automatic logic serving(seq_e st);
    return st inside {S_LDDE, S_LDA, S_STORE, S_INCDE, S_JUMP};
  endfunction

  // first byte of every instruction is an opcode, the rest are operands
  function automatic logic opcode_slot(seq_e st, logic [1:0] sub);
    return serving(st) && (sub == 2'd0);
  endfunction

  function automatic logic [1:0] last_sub(seq_e st);
    case (st)
      S_LDDE, S_JUMP: return 2'd2;
      S_LDA:          return 2'd1;
      default:        return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] inj_byte(seq_e st, logic [1:0] sub, logic [7:0] img);
    case (st)
      S_LDDE:  return (sub == 2'd0) ? OP_LD_DE : 8'h00;
      S_LDA:   return (sub == 2'd0) ? OP_LD_A  : img;
      S_STORE: return OP_ST_DE;
      S_INCDE: return OP_INC;
      S_JUMP:  return (sub == 2'd0) ? OP_JP    : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/zboot_clkdiv.sv
module zboot_clkdiv #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic cpu_clk
);
  localparam int DW = $clog2(CLK_DIV);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign cpu_clk = cnt[DW-1];

  // R1: a high phase lasts more than one clk
  p_cpu_clk_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk) |=> cpu_clk);
endmodule

// File: rtl/zboot_edges.sv
module zboot_edges #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] rise
);
  logic [N-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '1;
    else        q <= lvl_n;
  end

  assign rise = lvl_n & ~q;
endmodule

// File: rtl/zboot_seq.sv
module zboot_seq
  import zboot_pkg::*;
#(
  parameter int IMG_LEN  = 3,
  parameter int ADDR_W   = 8,
  parameter int RST_HOLD = 8,
  parameter int CLK_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              rd_rise,
  input  logic              wr_rise,
  input  logic [7:0]        rom_data,
  output logic [7:0]        d_out,
  output logic              d_oe,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              cpu_rst_n,
  output logic              done
);
  localparam int PAUSE_CLK = 2 * CLK_DIV;
  localparam int TMAX      = (RST_HOLD > PAUSE_CLK) ? RST_HOLD : PAUSE_CLK;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int CW        = $clog2(IMG_LEN + 1);

  seq_e          st;
  logic [1:0]    sub;
  logic [TW-1:0] tmr;
  logic [CW-1:0] copied;
  logic          hit;

  // named events
  logic slot_match, slot_done, byte_copied, image_full;

  assign slot_match  = serving(st) && !rd_n && (opcode_slot(st, sub) ? !m1_n : m1_n);
  assign slot_done   = rd_rise && hit;
  assign byte_copied = slot_done && (st == S_LDA) && (sub == 2'd1);
  assign image_full  = (copied == CW'(IMG_LEN));

  assign d_oe      = slot_match;
  assign d_out     = slot_match ? inj_byte(st, sub, rom_data) : 8'h00;
  assign rom_addr  = ADDR_W'(copied);
  assign cpu_rst_n = (st != S_HOLD);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_HOLD;
      sub    <= 2'd0;
      tmr    <= TW'(RST_HOLD - 1);
      copied <= '0;
      hit    <= 1'b0;
    end else begin
      if (slot_done)       hit <= 1'b0;
      else if (slot_match) hit <= 1'b1;
      if (byte_copied) copied <= copied + 1'b1;
      case (st)
        S_HOLD:  if (tmr == '0) st <= S_LDDE;
                 else tmr <= tmr - 1'b1;
        S_LDDE, S_LDA, S_JUMP:
          if (slot_done) begin
            if (sub == last_sub(st)) begin
              sub <= 2'd0;
              st  <= (st == S_LDDE) ? S_LDA : (st == S_LDA) ? S_STORE : S_DONE;
            end else begin
              sub <= sub + 1'b1;
            end
          end
        S_STORE: if (slot_done) st <= S_WRITE;
        S_WRITE: if (wr_rise)   st <= S_INCDE;
        S_INCDE: if (slot_done) begin
                   st  <= S_PAUSE;
                   tmr <= TW'(PAUSE_CLK - 1);
                 end
        S_PAUSE: if (tmr == '0) st <= image_full ? S_JUMP : S_LDA;
                 else tmr <= tmr - 1'b1;
        default: st <= S_DONE;
      endcase
    end
  end

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(copied) |-> (copied == $past(copied) + 1'b1));
  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRITE) |-> !d_oe);
  p_pause_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE) |-> !d_oe);
  p_jump_after_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_JUMP) |-> image_full);
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !d_oe));
  p_no_drive_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !d_oe);
endmodule

// File: rtl/zboot_injector.sv
module zboot_injector
  import zboot_pkg::*;
#(
  parameter int IMG_LEN  = 3,
  parameter int ADDR_W   = 8,
  parameter int RST_HOLD = 8,
  parameter int CLK_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cpu_clk,
  output logic              cpu_rst_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [7:0]        d_out,
  output logic              d_oe,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [7:0]        rom_data,
  output logic              ram_oe_allow,
  output logic              done
);
  logic [1:0] rise;

  zboot_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk)
  );

  zboot_edges #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl_n({wr_n, rd_n}), .rise(rise)
  );

  zboot_seq #(
    .IMG_LEN(IMG_LEN), .ADDR_W(ADDR_W), .RST_HOLD(RST_HOLD), .CLK_DIV(CLK_DIV)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .rd_n(rd_n),
    .rd_rise(rise[0]), .wr_rise(rise[1]), .rom_data(rom_data),
    .d_out(d_out), .d_oe(d_oe), .rom_addr(rom_addr),
    .cpu_rst_n(cpu_rst_n), .done(done)
  );

  assign ram_oe_allow = done;

  p_bus_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> !ram_oe_allow);
  p_cpu_reset_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst_n |-> !d_oe);
endmodule

// File: tb/zboot_injector_tb.sv
module zboot_injector_tb;
  localparam int IMG_LEN = 3, ADDR_W = 8, RST_HOLD = 8, CLK_DIV = 4;
  localparam int NV = 3 + 4 * IMG_LEN + 3;
  // kind[9:8]: 0 opcode, 1 fixed operand, 2 image operand, 3 store opcode
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 8'h11}, {2'd1, 8'h00}, {2'd1, 8'h00},
    {2'd0, 8'h3E}, {2'd2, 8'h00}, {2'd3, 8'h12}, {2'd0, 8'h13},
    {2'd0, 8'h3E}, {2'd2, 8'h00}, {2'd3, 8'h12}, {2'd0, 8'h13},
    {2'd0, 8'h3E}, {2'd2, 8'h00}, {2'd3, 8'h12}, {2'd0, 8'h13},
    {2'd0, 8'hC3}, {2'd1, 8'h00}, {2'd1, 8'h00}
  };

  logic clk = 0, rst_n = 0, m1_n = 1, rd_n = 1, wr_n = 1;
  logic cpu_clk, cpu_rst_n, d_oe, ram_oe_allow, done;
  logic [7:0] d_out, rom_data;
  logic [ADDR_W-1:0] rom_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] rom_byte(logic [ADDR_W-1:0] a);
    return 8'(a * 8'd37 + 8'd5);
  endfunction
  assign rom_data = rom_byte(rom_addr);

  zboot_injector #(.IMG_LEN(IMG_LEN), .ADDR_W(ADDR_W), .RST_HOLD(RST_HOLD),
                   .CLK_DIV(CLK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n),
    .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n), .d_out(d_out), .d_oe(d_oe),
    .rom_addr(rom_addr), .rom_data(rom_data), .ram_oe_allow(ram_oe_allow),
    .done(done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input bit m1, output logic oe, output logic [7:0] val);
    @(negedge clk); rd_n = 0; m1_n = !m1;
    repeat (2) @(negedge clk);
    oe = d_oe; val = d_out;
    @(negedge clk); rd_n = 1; m1_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_write(output logic oe);
    @(negedge clk); wr_n = 0;
    repeat (2) @(negedge clk);
    oe = d_oe;
    @(negedge clk); wr_n = 1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset cpu_rst_n", cpu_rst_n, 0);
    chk("R11 reset ram_oe_allow", ram_oe_allow, 0);
    chk("R10 reset done", done, 0);
    chk("R3 reset d_oe", d_oe, 0);
    rst_n = 1;
    rd_n = 0;  // read during hold must be ignored
    repeat (RST_HOLD - 1) @(negedge clk);
    chk("R2 still held", cpu_rst_n, 0);
    chk("R2 no drive in hold", d_oe, 0);
    rd_n = 1;
    @(negedge clk);
    chk("R2 released", cpu_rst_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic oe, woe;
    logic [7:0] v;
    int img, highs, rises;
    logic prev;
    do_reset();

    // R1: duty and rate
    highs = 0; rises = 0; prev = cpu_clk;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cpu_clk) highs++;
      if (cpu_clk && !prev) rises++;
      prev = cpu_clk;
    end
    chk("R1 high samples", highs, 20);
    chk("R1 rising edges", rises, 10);

    // R3: operand-type read at an opcode slot is ignored
    bus_read(0, oe, v);
    chk("R3 mismatched read not driven", oe, 0);

    img = 0;
    for (int k = 0; k < NV; k++) begin
      logic [1:0] kind;
      logic [7:0] exp;
      kind = VEC[k][9:8];
      exp  = (kind == 2'd2) ? rom_byte(ADDR_W'(img)) : VEC[k][7:0];
      chk("R11 ram blocked during stream", ram_oe_allow, 0);
      bus_read(kind == 2'd0 || kind == 2'd3, oe, v);
      chk($sformatf("R4 R5 R9 oe vec%0d", k), oe, 1);
      chk($sformatf("R4 R5 R9 byte vec%0d", k), v, exp);
      if (kind == 2'd2) begin
        img++;
        chk("R5 rom_addr step", rom_addr, img);
      end
      if (kind == 2'd3) begin
        bus_write(woe);
        chk("R6 write not driven", woe, 0);
      end
      if (kind == 2'd0 && VEC[k][7:0] == 8'h13) begin
        bus_read(1, oe, v);
        chk("R7 pause read ignored", oe, 0);
        repeat (10) @(negedge clk);
      end
    end
    chk("R8 images copied", img, IMG_LEN);
    chk("R10 done", done, 1);
    chk("R10 ram allowed", ram_oe_allow, 1);
    bus_read(1, oe, v);
    chk("R10 no drive after done", oe, 0);
    chk("R10 done sticky", done, 1);

    // R12: restart
    do_reset();
    chk("R12 addr cleared", rom_addr, 0);
    bus_read(1, oe, v);
    chk("R12 first byte", v, 8'h11);
    bus_read(0, oe, v);
    bus_read(0, oe, v);
    bus_read(1, oe, v);
    chk("R12 loop restarts", v, 8'h3E);
    chk("R12 done cleared", done, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule